// File: doc/BRIEF.md
# Dual-Space Effective Address Generator

This block turns the addressing fields of a memory-reference instruction into a final target and address. A 3-bit base field picks one of three outcomes. A zero value means the instruction works register-to-register and touches no memory. The values one to three name a base register whose contents are added to the displacement to reach main memory. Any value with its top bit set sends the reference to a private high-speed scratchpad. In that case the two low base bits become the top bits of the scratchpad address, and no base register is read.

Two instruction formats are handled. The normal format carries a 16-bit displacement. The short-page format uses only the low 12 bits of that field. A status flag lengthens main-memory displacements by 16 upper bits taken from a separate input, and leaves scratchpad addresses alone. A scratchpad reference only completes when the running process holds a reservation. Without one the block raises a fault instead of an access strobe. All results are registered and appear one cycle after the fields are presented.

Top module: `dual_space_agen`

## Requirements
- R1: A base field of 0 gives space code 00 (none), address 0 and no strobe.
- R2: Base field 1, 2 or 3 gives space code 01 (main) and asserts the strobe. The address is base register 1, 2 or 3 plus the zero-extended displacement.
- R3: A base field of the form 1xx in normal format gives space code 10 (scratchpad). The address is {xx, disp[15:0]}, an 18-bit value with every higher bit zero.
- R4: In short-page format (short_page=1), main-memory references use only disp[11:0], and disp[15:12] has no effect on the address.
- R5: A base field of the form 1xx in short-page format gives the 14-bit scratchpad address {xx, disp[11:0]}, with every higher bit zero.
- R6: With ext_disp=1, the main-memory displacement is {disp_hi, disp[15:0]} in normal format and {disp_hi, disp[11:0]} in short-page format.
- R7: ext_disp and disp_hi have no effect on scratchpad addresses.
- R8: A scratchpad reference made while resv_ok=0 raises fault, keeps space code 10 and its address, and issues no strobe. resv_ok has no effect on main-memory or register references.
- R9: Outputs are registered one cycle after req_valid. A cycle without req_valid gives all outputs zero, and reset clears all outputs.
- R10: The main-memory addition wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction fields valid this cycle |
| base_sel | input | 3 | Base field |
| disp | input | 16 | Displacement field |
| disp_hi | input | 16 | Upper displacement bits used when extended |
| short_page | input | 1 | 1 selects short-page format |
| ext_disp | input | 1 | Extended main-memory displacement flag |
| resv_ok | input | 1 | Scratchpad reservation granted |
| base_r1 | input | 32 | Base register 1 |
| base_r2 | input | 32 | Base register 2 |
| base_r3 | input | 32 | Base register 3 |
| strobe | output | 1 | Access strobe |
| space | output | 2 | Target: 00 none, 01 main, 10 scratchpad |
| addr | output | 32 | Effective address |
| fault | output | 1 | Scratchpad reference without reservation |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit displacement, a 12-bit short-page displacement and 16 extension bits. With these widths the extended normal displacement fills the whole address word. Base values near 2^32 then exercise the wrap of R10, and the scratchpad addresses sit at their full 18-bit and 14-bit limits. Directed corners are mixed with a long seeded run that covers every base value, format, flag and reservation state.

// File: rtl/dual_space_agen.sv
module dual_space_agen #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int SW = 12,
  parameter int XW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    base_sel,
  input  logic [DW-1:0] disp,
  input  logic [XW-1:0] disp_hi,
  input  logic          short_page,
  input  logic          ext_disp,
  input  logic          resv_ok,
  input  logic [AW-1:0] base_r1,
  input  logic [AW-1:0] base_r2,
  input  logic [AW-1:0] base_r3,
  output logic          strobe,
  output logic [1:0]    space,
  output logic [AW-1:0] addr,
  output logic          fault
);
  localparam logic [1:0] SP_NONE = 2'b00;
  localparam logic [1:0] SP_MAIN = 2'b01;
  localparam logic [1:0] SP_PAD  = 2'b10;

  logic [AW-1:0] base_val, m_disp, m_addr, p_addr;
  logic          to_pad, is_rr;

  assign is_rr  = (base_sel == 3'd0);
  assign to_pad = base_sel[2];

  always_comb begin
    case (base_sel[1:0])
      2'd1:    base_val = base_r1;
      2'd2:    base_val = base_r2;
      default: base_val = base_r3;
    endcase
  end

  always_comb begin
    case ({short_page, ext_disp})
      2'b00:   m_disp = AW'(disp);
      2'b01:   m_disp = AW'({disp_hi, disp});
      2'b10:   m_disp = AW'(disp[SW-1:0]);
      default: m_disp = AW'({disp_hi, disp[SW-1:0]});
    endcase
  end

  assign m_addr = base_val + m_disp;
  assign p_addr = short_page ? AW'({base_sel[1:0], disp[SW-1:0]})
                             : AW'({base_sel[1:0], disp});

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid || is_rr) begin
      strobe <= 1'b0;
      space  <= SP_NONE;
      addr   <= '0;
      fault  <= 1'b0;
    end else if (to_pad) begin
      strobe <= resv_ok;
      space  <= SP_PAD;
      addr   <= p_addr;
      fault  <= !resv_ok;
    end else begin
      strobe <= 1'b1;
      space  <= SP_MAIN;
      addr   <= m_addr;
      fault  <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_space_agen_chk.sv
module dual_space_agen_chk #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int SW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    base_sel,
  input logic          short_page,
  input logic          resv_ok,
  input logic          strobe,
  input logic [1:0]    space,
  input logic [AW-1:0] addr,
  input logic          fault
);
  // R1
  a_r1_reg_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && base_sel == 3'd0) |-> (space == 2'b00 && !strobe && addr == '0));
  // R2
  a_r2_main_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && base_sel != 3'd0 && !base_sel[2]) |-> (space == 2'b01 && strobe && !fault));
  // R3
  a_r3_pad_width: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && base_sel[2] && !short_page) |-> (space == 2'b10 && (addr >> (DW + 2)) == '0));
  // R5
  a_r5_short_pad_width: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && base_sel[2] && short_page) |-> (space == 2'b10 && (addr >> (SW + 2)) == '0));
  // R8
  a_r8_no_reservation: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && base_sel[2] && !resv_ok) |-> (fault && !strobe));
  a_r8_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (space == 2'b10 && !strobe));
  // R9
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (!strobe && !fault && space == 2'b00));
endmodule

bind dual_space_agen dual_space_agen_chk #(.AW(AW), .DW(DW), .SW(SW)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_sel(base_sel),
  .short_page(short_page), .resv_ok(resv_ok), .strobe(strobe),
  .space(space), .addr(addr), .fault(fault)
);

// File: tb/tb_dual_space_agen.sv
module tb_dual_space_agen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  base_sel = '0;
  logic [15:0] disp = '0, disp_hi = '0;
  logic        short_page = 1'b0, ext_disp = 1'b0, resv_ok = 1'b0;
  logic [31:0] base_r1 = '0, base_r2 = '0, base_r3 = '0;
  logic        strobe, fault;
  logic [1:0]  space;
  logic [31:0] addr;

  int checks = 0;
  int fails  = 0;

  logic        e_strobe, e_fault;
  logic [1:0]  e_space;
  logic [31:0] e_addr;
  string       e_tag;
  bit          e_live = 0;

  dual_space_agen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_sel(base_sel),
    .disp(disp), .disp_hi(disp_hi), .short_page(short_page), .ext_disp(ext_disp),
    .resv_ok(resv_ok), .base_r1(base_r1), .base_r2(base_r2), .base_r3(base_r3),
    .strobe(strobe), .space(space), .addr(addr), .fault(fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic model();
    longint unsigned b, d;
    if (!req_valid) begin
      e_strobe = 0; e_fault = 0; e_space = 2'b00; e_addr = 0; e_tag = "R9";
    end else if (base_sel == 0) begin
      e_strobe = 0; e_fault = 0; e_space = 2'b00; e_addr = 0; e_tag = "R1";
    end else if (base_sel >= 4) begin
      e_space = 2'b10;
      e_strobe = resv_ok;
      e_fault = !resv_ok;
      if (short_page) e_addr = (32'(base_sel - 4) << 12) + 32'(disp % 4096);
      else            e_addr = (32'(base_sel - 4) << 16) + 32'(disp);
      e_tag = !resv_ok ? "R8" : (ext_disp ? "R7" : (short_page ? "R5" : "R3"));
    end else begin
      b = (base_sel == 1) ? base_r1 : (base_sel == 2) ? base_r2 : base_r3;
      d = short_page ? (disp % 4096) : disp;
      if (ext_disp) d = d + (longint'(disp_hi) << (short_page ? 12 : 16));
      e_addr = 32'((b + d) % (64'd1 << 32));
      e_space = 2'b01; e_strobe = 1; e_fault = 0;
      e_tag = (b + d >= (64'd1 << 32)) ? "R10" : (ext_disp ? "R6" : (short_page ? "R4" : "R2"));
    end
  endtask

  task automatic compare();
    checks++;
    if (strobe !== e_strobe || fault !== e_fault || space !== e_space || addr !== e_addr) begin
      fails++;
      $display("FAIL %s: got strobe=%0b fault=%0b space=%b addr=%h, expected strobe=%0b fault=%0b space=%b addr=%h",
               e_tag, strobe, fault, space, addr, e_strobe, e_fault, e_space, e_addr);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] b, input logic [15:0] d,
                      input logic [15:0] dh, input bit sp, input bit ex, input bit ok);
    @(negedge clk);
    if (e_live) compare();
    req_valid = v; base_sel = b; disp = d; disp_hi = dh;
    short_page = sp; ext_disp = ex; resv_ok = ok;
    model();
    e_live = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    base_r1 = 32'h0001_0000; base_r2 = 32'hFFFF_FFF0; base_r3 = 32'h8000_0000;
    repeat (3) @(negedge clk);
    // R9: reset state
    e_strobe = 0; e_fault = 0; e_space = 0; e_addr = 0; e_tag = "R9";
    compare();
    rst_n = 1'b1;
    step(0, 3'd5, 16'h1234, 16'h0, 0, 0, 1);           // R9 idle
    step(1, 3'd0, 16'hFFFF, 16'hFFFF, 0, 1, 1);        // R1
    step(1, 3'd1, 16'h00FF, 16'h0, 0, 0, 1);           // R2
    step(1, 3'd3, 16'hFFFF, 16'h0, 0, 0, 0);           // R2/R8 resv ignored on main
    step(1, 3'd2, 16'h0020, 16'h0, 0, 0, 1);           // R10 wrap
    step(1, 3'd7, 16'hFFFF, 16'h0, 0, 0, 1);           // R3 top of scratchpad
    step(1, 3'd4, 16'h0000, 16'h0, 0, 0, 1);           // R3 bottom
    step(1, 3'd1, 16'hF123, 16'h0, 1, 0, 1);           // R4 upper disp ignored
    step(1, 3'd6, 16'hFABC, 16'h0, 1, 0, 1);           // R5
    step(1, 3'd1, 16'h0004, 16'hABCD, 0, 1, 1);        // R6 normal
    step(1, 3'd1, 16'hF004, 16'h0ABC, 1, 1, 1);        // R6 short
    step(1, 3'd5, 16'h1234, 16'hFFFF, 0, 1, 1);        // R7
    step(1, 3'd7, 16'h0FFF, 16'hFFFF, 1, 1, 1);        // R7 short
    step(1, 3'd6, 16'h4321, 16'h0, 0, 0, 0);           // R8 fault
    step(1, 3'd2, 16'hFFFF, 16'hFFFF, 0, 1, 1);        // R10 extended wrap
    step(0, 3'd1, 16'h1, 16'h0, 0, 0, 1);              // R9 back to idle
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) begin
        @(negedge clk);
        base_r1 = $urandom; base_r2 = $urandom; base_r3 = $urandom;
        model();
      end
      step(($urandom % 8) != 0, 3'($urandom), 16'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule